// File: doc/BRIEF.md
# T1 Transmit Elastic Store

This block sits between a system backplane and the T1 transmit line. The backplane delivers serial data on its own clock at either the T1 rate (1.544 MHz, 193-bit frames) or the E1 rate (2.048 MHz, 256-bit frames). An 8 kHz frame pulse marks the start of each system frame. The block keeps 192 payload bits per frame in a two-frame buffer and plays them out on the line clock. At each line frame it leaves one bit position empty as a placeholder for the framing bit, which a later stage inserts. With an E1-rate backplane, every fourth 8-bit timeslot is discarded so that 24 channels fill the T1 frame. A channel-block output tells the system side which timeslots are being discarded.

The write pointer crosses into the line domain as a Gray code through a two-flop synchronizer. The line side checks the buffer fill at every framing-bit position. If the buffer is close to empty, it repeats one whole frame. If it is close to full, it skips one whole frame. Each such slip sets sticky flags that record that it happened and in which direction. A strobe on the line side clears them.

When the backplane is frequency-locked to the line clock, a minimum-delay mode keeps the read pointer a short fixed distance behind the write pointer and turns slip handling off. A bypass setting sends the system data straight to the line, retimed by one line-clock register.

Top module: `t1_tx_elastic`

## Requirements
- R1: While reset is asserted and right after it is released, `line_fbit` is 1, `slip_flag`, `slip_empty` and `slip_full` are 0, and with the store enabled `line_data` is 0.
- R2: The line frame lasts 193 `line_clk` cycles. `line_fbit` is high in exactly one of them. With the store enabled, `line_data` is 0 in that cycle and the buffer is not read.
- R3: With `e1_mode`=0, a system frame is 193 bits. The bit presented together with `sys_sync` is the framing slot and is not stored. The following 192 bits are stored in order, and the write pointer moves only when a bit is stored.
- R4: With `e1_mode`=1, a system frame is 256 bits. Bit position p belongs to timeslot p/8, and the timeslots 0, 4, 8, 12, 16, 20, 24 and 28 (p[4:3]==0) are not stored. The remaining 192 bits are stored in order.
- R5: `sys_chblk` is high, in the same cycle as the bit it refers to, exactly when `e1_mode`=1 and the current position has p[4:3]==0. It is always low with `e1_mode`=0.
- R6: A high `sys_sync` forces the current bit to position 0, even in the middle of a frame. No bit is stored after reset until the first `sys_sync`.
- R7: Stored bits appear on `line_data` at the non-framing positions in the order they were written. After reset the read side starts one frame (192 payload positions) behind, so the first 192 payload bits are undefined and the first stored bit comes next. When the two clocks match in rate, no slip occurs.
- R8: At a framing position, if the fill is below GUARD bits, the read side moves back one frame, which repeats 192 payload bits. This sets `slip_flag` and `slip_empty` in the following cycle and leaves `slip_full` unchanged.
- R9: At a framing position, if the fill is above 384-GUARD bits, the read side skips one frame. This sets `slip_flag` and `slip_full` in the following cycle.
- R10: The slip flags stay set until `slip_clr` is high for a `line_clk` cycle, which clears all three. A slip in the same cycle takes priority over the clear.
- R11: With `es_en`=0, `line_data` equals `sys_data` as sampled on the previous `line_clk` edge, at every position, and no slip is raised.
- R12: When `min_dly` rises, the read pointer is placed MIN_LAG bits behind the synchronized write pointer, and no slip is raised while `min_dly` stays high. With locked clocks, a written bit reaches `line_data` within 32 line cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System backplane clock (T1 or E1 rate) |
| line_clk | input | 1 | Line transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| es_en | input | 1 | 1 = buffered, 0 = bypass |
| e1_mode | input | 1 | 0 = 193-bit system frame, 1 = 256-bit system frame |
| min_dly | input | 1 | Minimum-delay locked-clock mode (line domain) |
| sys_data | input | 1 | Serial system data |
| sys_sync | input | 1 | System frame pulse, marks position 0 |
| sys_chblk | output | 1 | High during discarded E1 timeslots |
| line_data | output | 1 | Serial line data |
| line_fbit | output | 1 | Strobe for the framing-bit placeholder |
| slip_clr | input | 1 | Clears the slip flags (line domain) |
| slip_flag | output | 1 | Sticky: a slip occurred |
| slip_empty | output | 1 | Sticky: a frame was repeated |
| slip_full | output | 1 | Sticky: a frame was deleted |

## Verification
`sys_chblk` is combinational, so it is checked 1 ns after the bit is driven. In bypass, `line_data` is checked on the next falling `line_clk` edge after the bit is driven. In buffered mode a scoreboard stores each bit that should be kept and compares it at the line output after the first frame's 192 payload positions. The line monitor runs on falling `line_clk` edges and uses `line_fbit` as its position reference, so synchronizer latency has no effect on the comparison. Slip flags update at a line framing position, so they are sampled on a `line_clk` falling edge after a whole system frame. The minimum-delay latency is measured in line cycles from the write edge of a single marker bit to its appearance on `line_data`.

// File: rtl/t1_tx_elastic.sv
module t1_tx_elastic #(
  parameter int FRAMES  = 2,
  parameter int GUARD   = 16,
  parameter int MIN_LAG = 16
) (
  input  logic sys_clk,
  input  logic line_clk,
  input  logic rst_n,
  input  logic es_en,
  input  logic e1_mode,
  input  logic min_dly,
  input  logic sys_data,
  input  logic sys_sync,
  output logic sys_chblk,
  output logic line_data,
  output logic line_fbit,
  input  logic slip_clr,
  output logic slip_flag,
  output logic slip_empty,
  output logic slip_full
);
  localparam int PAY   = 192;
  localparam int DEPTH = PAY * FRAMES;
  localparam int AW    = $clog2(DEPTH);
  localparam int SPAN  = 1 << AW;
  localparam int OFS   = (SPAN - DEPTH) / 2;
  localparam int LW    = $clog2(PAY + 1);

  function automatic logic [AW-1:0] g2b(input logic [AW-1:0] g);
    logic [AW-1:0] b;
    b[AW-1] = g[AW-1];
    for (int i = AW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic mem [DEPTH];

  // system (write) side
  logic [7:0]    wcnt, pos, wlast;
  logic          wsynced, drop, wr_en;
  logic [AW-1:0] wbin, wnext, wgray, waddr;

  assign pos       = sys_sync ? 8'd0 : wcnt;
  assign wlast     = e1_mode ? 8'd255 : 8'(PAY);
  assign drop      = e1_mode ? (pos[4:3] == 2'b00) : (pos == 8'd0);
  assign sys_chblk = e1_mode && (pos[4:3] == 2'b00);
  assign wr_en     = es_en && (wsynced || sys_sync) && !drop;
  assign wnext     = (wbin == AW'(OFS + DEPTH - 1)) ? AW'(OFS) : wbin + 1'b1;
  assign waddr     = wbin - AW'(OFS);

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt    <= '0;
      wsynced <= 1'b0;
      wbin    <= AW'(OFS);
      wgray   <= AW'(OFS) ^ (AW'(OFS) >> 1);
    end else begin
      wcnt    <= (pos == wlast) ? 8'd0 : pos + 8'd1;
      wsynced <= wsynced | sys_sync;
      if (wr_en) begin
        wbin  <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
    end
  end

  always_ff @(posedge sys_clk) begin
    if (wr_en) mem[waddr] <= sys_data;
  end

  // R3
  wptr_hold_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !wr_en |=> $stable(wgray));

  // line (read) side
  logic [AW-1:0] gs1, gs2, wsync, rptr;
  logic [AW:0]   fill;
  logic [LW-1:0] lcnt;
  logic          fpos, min_q, min_go, chk_now, emp, ful, byp_q;

  assign wsync   = g2b(gs2) - AW'(OFS);
  assign fill    = (wsync >= rptr) ? {1'b0, wsync} - {1'b0, rptr}
                                   : {1'b0, wsync} + (AW+1)'(DEPTH) - {1'b0, rptr};
  assign fpos    = (lcnt == '0);
  assign min_go  = min_dly && !min_q;
  assign chk_now = es_en && !min_dly && fpos;
  assign emp     = chk_now && (fill < (AW+1)'(GUARD));
  assign ful     = chk_now && (fill > (AW+1)'(DEPTH - GUARD));

  assign line_fbit = fpos;
  assign line_data = !es_en ? byp_q : (fpos ? 1'b0 : mem[rptr]);

  always_ff @(posedge line_clk or negedge rst_n) begin
    if (!rst_n) begin
      gs1        <= AW'(OFS) ^ (AW'(OFS) >> 1);
      gs2        <= AW'(OFS) ^ (AW'(OFS) >> 1);
      rptr       <= AW'(PAY);
      lcnt       <= '0;
      min_q      <= 1'b0;
      byp_q      <= 1'b0;
      slip_flag  <= 1'b0;
      slip_empty <= 1'b0;
      slip_full  <= 1'b0;
    end else begin
      gs1   <= wgray;
      gs2   <= gs1;
      min_q <= min_dly;
      byp_q <= sys_data;
      lcnt  <= (lcnt == LW'(PAY)) ? '0 : lcnt + 1'b1;

      if (min_go)
        rptr <= (wsync >= AW'(MIN_LAG)) ? wsync - AW'(MIN_LAG) : wsync + AW'(DEPTH - MIN_LAG);
      else if (emp)
        rptr <= (rptr >= AW'(PAY)) ? rptr - AW'(PAY) : rptr + AW'(DEPTH - PAY);
      else if (ful)
        rptr <= (rptr >= AW'(DEPTH - PAY)) ? rptr - AW'(DEPTH - PAY) : rptr + AW'(PAY);
      else if (es_en && !fpos)
        rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;

      if (emp || ful)    slip_flag <= 1'b1;
      else if (slip_clr) slip_flag <= 1'b0;
      if (emp)           slip_empty <= 1'b1;
      else if (slip_clr) slip_empty <= 1'b0;
      if (ful)           slip_full <= 1'b1;
      else if (slip_clr) slip_full <= 1'b0;
    end
  end

  // R2
  fbit_single_chk: assert property (@(posedge line_clk) disable iff (!rst_n)
    line_fbit |=> !line_fbit);

  // R7
  fbit_noread_chk: assert property (@(posedge line_clk) disable iff (!rst_n)
    line_fbit && es_en && !min_go && !slip_flag && !min_dly |=> $stable(rptr) || slip_flag);

  // R7
  rptr_range_chk: assert property (@(posedge line_clk) disable iff (!rst_n)
    rptr < AW'(DEPTH));

  // R10
  flag_hold_chk: assert property (@(posedge line_clk) disable iff (!rst_n)
    slip_flag && !slip_clr |=> slip_flag);

  // R8
  dir_flag_chk: assert property (@(posedge line_clk) disable iff (!rst_n)
    (slip_empty || slip_full) |-> slip_flag);

  // R12
  min_quiet_chk: assert property (@(posedge line_clk) disable iff (!rst_n)
    min_dly && !slip_flag |=> !slip_flag);

endmodule

// File: tb/sim_t1_tx_elastic.sv
`timescale 1ns/1ps
module sim_t1_tx_elastic;
  logic sys_clk = 1'b0, line_clk = 1'b0, rst_n = 1'b0;
  logic es_en = 1'b1, e1_mode = 1'b0, min_dly = 1'b0;
  logic sys_data = 1'b0, sys_sync = 1'b0, slip_clr = 1'b0;
  logic sys_chblk, line_data, line_fbit, slip_flag, slip_empty, slip_full;

  real sys_half = 10.0;
  int  n_chk = 0, n_fail = 0;
  bit  q[$];
  bit  mon_on = 0, chk_data = 0, blk_chk = 0, zero_data = 0;
  bit  marker_req = 0, mark_wait = 0, mark_seen = 0;
  real marker_t = 0.0;
  int  lat = 0, pay = 0, last_f = -1, lcyc = 0;
  string cur_tag = "R7";

  t1_tx_elastic u0 (
    .sys_clk(sys_clk), .line_clk(line_clk), .rst_n(rst_n), .es_en(es_en),
    .e1_mode(e1_mode), .min_dly(min_dly), .sys_data(sys_data), .sys_sync(sys_sync),
    .sys_chblk(sys_chblk), .line_data(line_data), .line_fbit(line_fbit),
    .slip_clr(slip_clr), .slip_flag(slip_flag), .slip_empty(slip_empty),
    .slip_full(slip_full)
  );

  initial forever #10 line_clk = ~line_clk;
  initial begin #3; forever #(sys_half) sys_clk = ~sys_clk; end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // scoreboard monitor: pops one expected bit per payload position
  always @(negedge line_clk) begin
    lcyc++;
    if (mon_on) begin
      if (line_fbit) begin
        if (chk_data) begin
          chk(line_data == 1'b0, "R2", int'(line_data), 0);
          if (last_f >= 0) chk(lcyc - last_f == 193, "R2", lcyc - last_f, 193);
        end
        last_f = lcyc;
      end else begin
        pay++;
        if (mark_wait && line_data) begin
          lat = int'(($realtime - marker_t) / 20.0);
          mark_wait = 0;
          mark_seen = 1;
        end
        if (chk_data && pay > 192) begin
          if (q.size() == 0) chk(1'b0, cur_tag, 0, 1);
          else begin
            bit e;
            e = q.pop_front();
            chk(line_data == e, cur_tag, int'(line_data), int'(e));
          end
        end
      end
    end
  end

  task automatic do_reset(input bit en, input bit e1, input real half);
    mon_on = 0; chk_data = 0; blk_chk = 0;
    rst_n = 0; es_en = en; e1_mode = e1; min_dly = 0; sys_half = half;
    sys_sync = 0; sys_data = 0; slip_clr = 0;
    q.delete(); pay = 0; last_f = -1;
    #100;
    @(negedge line_clk); #2; rst_n = 1; #1;
    // R1
    chk(line_fbit == 1'b1, "R1", int'(line_fbit), 1);
    chk({slip_flag, slip_empty, slip_full} == 3'b000, "R1",
        int'({slip_flag, slip_empty, slip_full}), 0);
    if (en) chk(line_data == 1'b0, "R1", int'(line_data), 0);
    mon_on = 1;
    // R6: bits before the first frame pulse must not be stored
    repeat (5) begin
      @(negedge sys_clk);
      sys_data = 1'($urandom);
    end
  endtask

  task automatic drive_frames(input int n, input int cut);
    for (int f = 0; f < n; f++) begin
      int flen;
      flen = e1_mode ? 256 : 193;
      if (cut > 0 && f == 1) flen = cut;
      for (int p = 0; p < flen; p++) begin
        logic d, drop;
        logic [7:0] pb;
        pb = 8'(p);
        @(negedge sys_clk);
        drop = e1_mode ? (pb[4:3] == 2'b00) : (p == 0);
        d = zero_data ? 1'b0 : 1'($urandom);
        if (marker_req && !drop && p == 60) begin
          d = 1'b1;
          marker_req = 0;
          marker_t = $realtime + sys_half;
        end
        sys_sync = (p == 0);
        sys_data = d;
        if (!drop) q.push_back(d);
        if (blk_chk) begin
          #1;
          // R5 (and R6 after the early frame pulse)
          chk(sys_chblk == (e1_mode && pb[4:3] == 2'b00), "R5", int'(sys_chblk),
              int'(e1_mode && pb[4:3] == 2'b00));
        end
      end
    end
  endtask

  task automatic run_to_slip();
    for (int f = 0; f < 45; f++) begin
      drive_frames(1, 0);
      @(negedge line_clk);
      if (slip_flag) break;
    end
  endtask

  task automatic clear_flags();
    @(negedge line_clk); slip_clr = 1;
    @(negedge line_clk); slip_clr = 0;
    #1;
    // R10
    chk({slip_flag, slip_empty, slip_full} == 3'b000, "R10",
        int'({slip_flag, slip_empty, slip_full}), 0);
  endtask

  initial begin
    // T1 backplane, matched rate: R3, R5, R6, R7
    do_reset(1, 0, 10.0);
    zero_data = 0; chk_data = 1; blk_chk = 1; cur_tag = "R3";
    drive_frames(6, 0);
    chk_data = 0; blk_chk = 0;
    chk(slip_flag == 1'b0, "R7", int'(slip_flag), 0);

    // E1 backplane with one shortened frame: R4, R5, R6
    do_reset(1, 1, 7.539);
    chk_data = 1; blk_chk = 1; cur_tag = "R4";
    drive_frames(6, 100);
    chk_data = 0; blk_chk = 0;
    chk(slip_flag == 1'b0, "R6", int'(slip_flag), 0);

    // slow backplane: empty slip R8, sticky and clear R10
    do_reset(1, 0, 10.5);
    run_to_slip();
    chk(slip_flag == 1'b1, "R8", int'(slip_flag), 1);
    chk(slip_empty == 1'b1, "R8", int'(slip_empty), 1);
    chk(slip_full == 1'b0, "R8", int'(slip_full), 0);
    repeat (50) @(negedge line_clk);
    chk(slip_flag && slip_empty, "R10", int'(slip_flag), 1);
    clear_flags();

    // fast backplane: full slip R9
    do_reset(1, 0, 9.5);
    run_to_slip();
    chk(slip_flag == 1'b1, "R9", int'(slip_flag), 1);
    chk(slip_full == 1'b1, "R9", int'(slip_full), 1);
    chk(slip_empty == 1'b0, "R9", int'(slip_empty), 0);
    clear_flags();

    // bypass: R11
    do_reset(0, 0, 10.0);
    begin
      logic prev;
      prev = 1'b0;
      for (int i = 0; i < 300; i++) begin
        logic d;
        @(negedge line_clk);
        if (i > 0) chk(line_data == prev, "R11", int'(line_data), int'(prev));
        d = 1'($urandom);
        sys_data = d;
        prev = d;
      end
    end
    chk(slip_flag == 1'b0, "R11", int'(slip_flag), 0);

    // minimum-delay mode with locked clocks: R12
    do_reset(1, 0, 10.0);
    zero_data = 1;
    drive_frames(3, 0);
    @(negedge line_clk); min_dly = 1;
    drive_frames(2, 0);
    chk(slip_flag == 1'b0, "R12", int'(slip_flag), 0);
    mark_seen = 0; mark_wait = 1; marker_req = 1;
    drive_frames(1, 0);
    repeat (40) @(negedge line_clk);
    chk(mark_seen == 1'b1, "R12", int'(mark_seen), 1);
    chk(lat <= 32, "R12", lat, 32);
    chk(slip_flag == 1'b0, "R12", int'(slip_flag), 0);
    min_dly = 0; zero_data = 0; mark_wait = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule